// File: doc/BRIEF.md
# Key Wake-up Interrupt Port

This block watches two 8-bit input ports, G and H, and turns a high-to-low transition on any pin into a latched event. Each pin owns a sticky flag that records the event whether or not the pin is enabled. Each pin also owns an enable bit that decides whether its flag reaches the single combined interrupt line. Software uses a small register bus to reach two enable registers and two flag registers. A flag is cleared by writing 1 to its bit.

Pin 6 of port G can be switched into a start-detect mode. In that mode, a falling edge on pin 6 counts only when pin 7 of the same port is high at that moment. This is the Start condition of an I2C bus, with pin 6 as SDA and pin 7 as SCL. The same mode bit drives an output that tells the pad logic to run pins 6 and 7 of port G open-drain. Every pin passes through a two-flop synchroniser before edge detection, so the pins may be asynchronous to the clock.

Top module: `kwu_port_irq`

## Requirements
- R1: After reset, all four registers read 0, `irq` is 0 and `od_mode` is 0.
- R2: The port G enable register (offset 0x2C) and the port H enable register (offset 0x2D) hold any 8-bit value written to them and read it back at any time.
- R3: A falling edge on any pin sets that pin's flag bit, whether or not the pin is enabled. Port G flags read at 0x2E and port H flags at 0x2F, with bit n belonging to pin n. The flag is visible three clock edges after the new level is presented.
- R4: A rising edge, or a level that does not change, sets no flag.
- R5: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged, and flags stay set until cleared.
- R6: If an event and a write-1-to-clear reach the same flag in the same cycle, the flag ends set.
- R7: `irq` is 1 exactly when some flag bit and its enable bit are both 1. Bit 7 of port G is the mode select, has no flag (it always reads 0 at 0x2E) and never raises `irq`.
- R8: With bit 7 of the port G enable register at 0, pin 6 of port G sets its flag on any falling edge, whatever the level of pin 7.
- R9: With that mode bit at 1, a falling edge on pin 6 of port G sets its flag only when pin 7 of port G is high. With pin 7 low it sets nothing.
- R10: `od_mode` equals bit 7 of the port G enable register.
- R11: Reads at any other address return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_g | input | 8 | Port G pin levels, asynchronous |
| pin_h | input | 8 | Port H pin levels, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Combined wake-up interrupt |
| od_mode | output | 1 | Open-drain request for port G pins 6 and 7 |

## Verification
The bench drops each of the sixteen pins in turn. A design that cross-wired a pin or a port would flag the wrong bit, and one that gated flags by enable would lose the flag of a disabled pin. The start-mode cases pair pin 6 with pin 7 low in both modes: a design that ignored the mode would flag in start mode with pin 7 low, and one that always qualified would miss the plain edge. A clear is timed to land on the same edge as a fresh event, where a clear-wins priority would drop the flag. Other tests write 0x7F to port G with only the pin 7 line low, clear with 0 bits, and touch an unmapped address. These catch a phantom bit-7 interrupt, over-eager clearing and aliased decoding.

// File: rtl/kwu_pkg.sv
package kwu_pkg;

    // Register selected by the current bus address
    typedef enum logic [2:0] {
        SEL_EN_G,
        SEL_EN_H,
        SEL_FL_G,
        SEL_FL_H,
        SEL_NONE
    } reg_sel_e;

    // Offsets of the four registers from the block base address
    localparam int OFS_EN_G = 0;
    localparam int OFS_EN_H = 1;
    localparam int OFS_FL_G = 2;
    localparam int OFS_FL_H = 3;

endpackage

// File: rtl/kwu_sync.sv
module kwu_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/kwu_event.sv
module kwu_event #(
    parameter int W         = 8,
    parameter bit HAS_START = 1'b0,
    parameter int START_PIN = 6,
    parameter int SCL_PIN   = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic         start_mode,
    output logic [W-1:0] evt
);
    // Bits whose event is qualified by the clock-pin level in start mode
    localparam logic [W-1:0] START_MASK =
        HAS_START ? (W'(1) << START_PIN) : '0;

    typedef struct packed {
        logic [W-1:0] prev;
    } evt_st_t;

    evt_st_t st_d, st_q;
    logic [W-1:0] veto;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        // In start mode, a low clock pin vetoes the data-pin edge
        veto = START_MASK & {W{start_mode & ~lvl[SCL_PIN]}};
        evt  = st_q.prev & ~lvl & ~veto;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/kwu_flags.sv
module kwu_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] flag
);
    typedef struct packed {
        logic [W-1:0] f;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        // A new event overrides a clear in the same cycle
        st_d.f = (st_q.f & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.f;
endmodule

// File: rtl/kwu_port_irq.sv
module kwu_port_irq
    import kwu_pkg::*;
#(
    parameter int                PORT_W    = 8,
    parameter int                START_PIN = 6,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_g,
    input  logic [PORT_W-1:0] pin_h,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    output logic              irq,
    output logic              od_mode
);
    localparam int NPORT    = 2;
    localparam int MODE_BIT = PORT_W - 1;
    localparam int SCL_PIN  = PORT_W - 1;
    // Port G top bit is the mode select and carries no flag
    localparam logic [PORT_W-1:0] G_MASK = {1'b0, {(PORT_W-1){1'b1}}};

    typedef struct packed {
        logic [PORT_W-1:0] en_g;
        logic [PORT_W-1:0] en_h;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [NPORT-1:0][PORT_W-1:0] lvl;
    logic [NPORT-1:0][PORT_W-1:0] evt;
    logic [NPORT-1:0][PORT_W-1:0] flg;
    logic [NPORT-1:0][PORT_W-1:0] clr;
    logic [NPORT*PORT_W-1:0]      lvl_flat;
    reg_sel_e                     sel;
    logic [ADDR_W-1:0]            ofs;
    logic                         wr_stb;

    // Input synchroniser for both ports
    kwu_sync #(.W(NPORT*PORT_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({pin_h, pin_g}),
        .q    (lvl_flat)
    );
    assign lvl = lvl_flat;

    // Address decode
    always_comb begin
        ofs = bus_addr - BASE_ADDR;
        if      (ofs == ADDR_W'(OFS_EN_G)) sel = SEL_EN_G;
        else if (ofs == ADDR_W'(OFS_EN_H)) sel = SEL_EN_H;
        else if (ofs == ADDR_W'(OFS_FL_G)) sel = SEL_FL_G;
        else if (ofs == ADDR_W'(OFS_FL_H)) sel = SEL_FL_H;
        else                               sel = SEL_NONE;
    end

    assign wr_stb = bus_sel & bus_wr;

    // Per-port event detection and flag storage; port 0 is G, port 1 is H
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam logic [PORT_W-1:0] FMASK = (p == 0) ? G_MASK : '1;
        localparam reg_sel_e          FSEL  = (p == 0) ? SEL_FL_G : SEL_FL_H;

        kwu_event #(
            .W        (PORT_W),
            .HAS_START(p == 0),
            .START_PIN(START_PIN),
            .SCL_PIN  (SCL_PIN)
        ) u_evt (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl       (lvl[p]),
            .start_mode(cfg_q.en_g[MODE_BIT]),
            .evt       (evt[p])
        );

        assign clr[p] = (wr_stb && sel == FSEL) ? bus_wdata : '0;

        kwu_flags #(.W(PORT_W)) u_flg (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (evt[p] & FMASK),
            .clr  (clr[p]),
            .flag (flg[p])
        );
    end

    // Enable register next state
    always_comb begin
        cfg_d = cfg_q;
        if (wr_stb) begin
            case (sel)
                SEL_EN_G: cfg_d.en_g = bus_wdata;
                SEL_EN_H: cfg_d.en_h = bus_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // Read mux
    always_comb begin
        case (sel)
            SEL_EN_G: bus_rdata = cfg_q.en_g;
            SEL_EN_H: bus_rdata = cfg_q.en_h;
            SEL_FL_G: bus_rdata = flg[0];
            SEL_FL_H: bus_rdata = flg[1];
            default:  bus_rdata = '0;
        endcase
    end

    assign irq     = |(flg[0] & cfg_q.en_g & G_MASK) | |(flg[1] & cfg_q.en_h);
    assign od_mode = cfg_q.en_g[MODE_BIT];
endmodule

// File: rtl/kwu_port_irq_chk.sv
module kwu_port_irq_chk #(
    parameter int                PORT_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h2C
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_sel,
    input logic                   bus_wr,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [PORT_W-1:0]      bus_wdata,
    input logic [PORT_W-1:0]      bus_rdata,
    input logic                   irq,
    input logic                   od_mode,
    input logic [1:0][PORT_W-1:0] evt,
    input logic [1:0][PORT_W-1:0] flg
);
    localparam logic [ADDR_W-1:0] A_EN_G = BASE_ADDR;
    localparam logic [ADDR_W-1:0] A_FL_G = BASE_ADDR + ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_FL_H = BASE_ADDR + ADDR_W'(3);

    // R7: no flag set means no interrupt
    assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flg[0] == '0 && flg[1] == '0) |-> !irq);

    // R7: port G flag register bit 7 always reads 0
    assert_gtop_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == A_FL_G) |-> !bus_rdata[PORT_W-1]);

    // R10: open-drain output follows the mode bit written to port G enable
    assert_od_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_EN_G) |=> (od_mode == $past(bus_wdata[PORT_W-1])));

    // R5: without a clear write, port H flags never drop
    assert_sticky_h_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == A_FL_H) |=> ((flg[1] & $past(flg[1])) == $past(flg[1])));

    // R5: without a clear write, port G flags never drop
    assert_sticky_g_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == A_FL_G) |=> ((flg[0] & $past(flg[0])) == $past(flg[0])));

    // R6: a port H event always leaves its flag set, clear or not
    assert_evt_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[1] != '0) |=> ((flg[1] & $past(evt[1])) == $past(evt[1])));
endmodule

bind kwu_port_irq kwu_port_irq_chk #(
    .PORT_W   (PORT_W),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .od_mode  (od_mode),
    .evt      (evt),
    .flg      (flg)
);

// File: tb/kwu_port_irq_bench.sv
`timescale 1ns/1ps
module kwu_port_irq_bench;
    localparam logic [7:0] A_EN_G = 8'h2C;
    localparam logic [7:0] A_EN_H = 8'h2D;
    localparam logic [7:0] A_FL_G = 8'h2E;
    localparam logic [7:0] A_FL_H = 8'h2F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_g = 8'hFF;
    logic [7:0] pin_h = 8'hFF;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       od_mode;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    kwu_port_irq u_kwu_port_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_g    (pin_g),
        .pin_h    (pin_h),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq),
        .od_mode  (od_mode)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pins(input logic [7:0] g, input logic [7:0] h);
        @(negedge clk);
        pin_g = g; pin_h = h;
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_all();
        wr(A_FL_G, 8'hFF);
        wr(A_FL_H, 8'hFF);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] eg, eh;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        rd(A_EN_G, v); check("R1 en_g", v, 8'h00);
        rd(A_EN_H, v); check("R1 en_h", v, 8'h00);
        rd(A_FL_G, v); check("R1 fl_g", v, 8'h00);
        rd(A_FL_H, v); check("R1 fl_h", v, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 od", {7'b0, od_mode}, 8'h00);

        // R2: enable readback patterns
        foreach (eg[k]) begin
            logic [7:0] pat;
            pat = 8'hA5 ^ (8'h11 << k[2:0]);
            wr(A_EN_G, pat); rd(A_EN_G, v); check("R2 en_g", v, pat);
            wr(A_EN_H, ~pat); rd(A_EN_H, v); check("R2 en_h", v, ~pat);
        end
        wr(A_EN_G, 8'h00); wr(A_EN_H, 8'h00);

        // Per-pin sweep over all sixteen pins (start mode off)
        for (int i = 0; i < 16; i++) begin
            int b;
            logic [7:0] bit_m;
            b = i % 8;
            bit_m = 8'(1) << b;
            clear_all();
            if (i < 8) pins(8'hFF & ~bit_m, 8'hFF);
            else       pins(8'hFF, 8'hFF & ~bit_m);
            eg = (i < 8 && b != 7) ? bit_m : 8'h00;
            eh = (i >= 8) ? bit_m : 8'h00;
            // R3: flag set though disabled
            rd(A_FL_G, v); check("R3 fl_g", v, eg);
            rd(A_FL_H, v); check("R3 fl_h", v, eh);
            check("R7 irq disabled", {7'b0, irq}, 8'h00);
            // R7: enable raises irq; port G bit 7 never does
            if (i < 8) wr(A_EN_G, (b == 7) ? 8'h7F : bit_m);
            else       wr(A_EN_H, bit_m);
            check("R7 irq enabled", {7'b0, irq}, (i < 8 && b == 7) ? 8'h00 : 8'h01);
            // R4: rising edge leaves flags as they were
            pins(8'hFF, 8'hFF);
            rd(A_FL_G, v); check("R4 fl_g", v, eg);
            rd(A_FL_H, v); check("R4 fl_h", v, eh);
            // R5: writing 0 bits keeps the flag, writing 1 clears it
            wr((i < 8) ? A_FL_G : A_FL_H, ~bit_m);
            rd((i < 8) ? A_FL_G : A_FL_H, v);
            check("R5 keep", v, (i < 8) ? eg : eh);
            wr((i < 8) ? A_FL_G : A_FL_H, bit_m);
            rd((i < 8) ? A_FL_G : A_FL_H, v);
            check("R5 clear", v, 8'h00);
            check("R5 irq after clear", {7'b0, irq}, 8'h00);
            wr(A_EN_G, 8'h00); wr(A_EN_H, 8'h00);
        end

        // R4: steady levels set nothing
        clear_all();
        repeat (10) @(negedge clk);
        rd(A_FL_G, v); check("R4 steady g", v, 8'h00);
        rd(A_FL_H, v); check("R4 steady h", v, 8'h00);

        // R8: mode off, pin 6 edge counts with pin 7 low
        pins(8'h7F, 8'hFF);
        clear_all();
        pins(8'h3F, 8'hFF);
        rd(A_FL_G, v); check("R8 plain edge", v, 8'h40);
        pins(8'hFF, 8'hFF);
        clear_all();

        // R10 / R9: start mode
        wr(A_EN_G, 8'hC0);
        check("R10 od on", {7'b0, od_mode}, 8'h01);
        pins(8'hBF, 8'hFF);
        rd(A_FL_G, v); check("R9 start seen", v, 8'h40);
        check("R9 irq", {7'b0, irq}, 8'h01);
        pins(8'hFF, 8'hFF);
        clear_all();
        pins(8'h7F, 8'hFF);
        clear_all();
        pins(8'h3F, 8'hFF);
        rd(A_FL_G, v); check("R9 blocked", v, 8'h00);
        check("R9 irq blocked", {7'b0, irq}, 8'h00);
        pins(8'hFF, 8'hFF);
        clear_all();
        wr(A_EN_G, 8'h40);
        check("R10 od off", {7'b0, od_mode}, 8'h00);
        wr(A_EN_G, 8'h00);

        // R6: event and clear on the same edge
        pins(8'hFF, 8'hFE);
        pins(8'hFF, 8'hFF);
        rd(A_FL_H, v); check("R6 preset", v, 8'h01);
        @(negedge clk);
        pin_h = 8'hFE;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_FL_H; bus_wdata = 8'h01;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(A_FL_H, v); check("R6 event wins", v, 8'h01);
        pins(8'hFF, 8'hFF);
        clear_all();

        // R11: unmapped address
        wr(A_EN_H, 8'h3C);
        wr(8'h30, 8'hFF);
        wr(8'h2B, 8'hFF);
        rd(8'h30, v); check("R11 read 30", v, 8'h00);
        rd(8'h2B, v); check("R11 read 2B", v, 8'h00);
        rd(A_EN_G, v); check("R11 en_g kept", v, 8'h00);
        rd(A_EN_H, v); check("R11 en_h kept", v, 8'h3C);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule